// File: doc/BRIEF.md
# Per-Subcarrier Programmable Constellation Mapper

This block turns a serial stream of coded bits into one complex sample per subcarrier, walking the subcarriers of a symbol in ascending order and feeding the result to an inverse FFT. The modulation is not fixed for the whole symbol. Each subcarrier has its own 4-bit code in an info table, and that code sets both how many bits the subcarrier takes and which constellation is used. The amplitudes are not hard-wired. They come from a runtime level table, so software can load non-standard or scaled constellations.

A subcarrier whose code is switched off yields a zero sample. It does not draw any bits from the stream, but the subcarrier index still moves on. This is how a non-contiguous spectrum is carved out: the bins that are switched off stay silent while the others carry data.

A three-state machine drives the block. FETCH reads the code for the current subcarrier index and advances the index. It takes the transition FETCH to GATHER when the code is active, and FETCH to MAP when the code is inactive. GATHER accepts one bit per valid beat. It loops on GATHER to GATHER until the last bit the code needs arrives, and then takes GATHER to MAP. MAP forms the I/Q pair and always returns through MAP to FETCH. Two register stages then carry the sample to the output.

Top module: `cmap_mapper`

## Requirements
- R1: While reset is held, out_valid, in_ready, out_i and out_q are all 0. After reset the first subcarrier handled is index 0.
- R2: The number of bits an active subcarrier takes from the stream is 1 for type 0 (BPSK), 2 for type 1 (QPSK), 4 for type 2 (16QAM) and 6 for type 3 (64QAM). The type is code bits [2:0]. in_ready drops as soon as the last bit has been taken.
- R3: For BPSK, I = +L1 when bit b0 is 0 and -L1 when b0 is 1, and Q = 0. The bits are numbered b0, b1, ... in arrival order. L1..L13 are level table entries 0..12, with entry k held in lvl_tbl[16k+15:16k].
- R4: For QPSK, I = ±L2 signed by b0 and Q = ±L3 signed by b1. A bit value of 0 gives the positive sign.
- R5: For 16QAM, I has sign b0 and magnitude L4 when b1=0 or L5 when b1=1. Q has sign b2 and magnitude L6 when b3=0 or L7 when b3=1.
- R6: For 64QAM, I has sign b0 and a magnitude chosen by {b2,b1}: 0, L8, L9 or L10 for the values 0 to 3. Q has sign b3 and a magnitude chosen by {b5,b4}: 0, L11, L12 or L13.
- R7: A subcarrier is active only when code bit 3 is 1 and its type is 0 to 3. An inactive subcarrier, including one with type 4 to 7, outputs I = Q = 0, consumes no bits and never raises in_ready.
- R8: Each output carries its subcarrier index in out_sc. Successive outputs step the index by one and wrap from NUM_SC-1 back to 0, and inactive subcarriers are included in the sequence.
- R9: out_valid rises exactly two clock edges after the edge that accepts the last bit of an active subcarrier, and it is high for a single cycle per subcarrier.
- R10: Level values are read from the table when the sample is formed, so reloading the table changes the amplitudes of later subcarriers with no other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| info_tbl | input | NUM_SC*4 | Per-subcarrier codes, entry j at bits [4j+3:4j] |
| lvl_tbl | input | 13*LW | Level values L1..L13, entry k at bits [LW*k+LW-1:LW*k] |
| in_valid | input | 1 | Coded bit present |
| in_bit | input | 1 | Coded bit |
| in_ready | output | 1 | Mapper takes in_bit on this edge if in_valid |
| out_valid | output | 1 | Sample valid, one cycle |
| out_i | output | LW | Signed in-phase sample |
| out_q | output | LW | Signed quadrature sample |
| out_sc | output | $clog2(NUM_SC) | Subcarrier index of the sample |

## Verification
The assertions assume that both tables stay steady while a subcarrier is in flight: the info table from FETCH onward and the level table around MAP. The bench meets this by loading every table change under reset. The assertions also assume that in_bit is only meaningful when in_valid is high. The bench lowers in_valid whenever it is not offering a bit, so an extra bit is never taken by accident. To check that inactive subcarriers draw nothing, the bench holds in_valid high over a whole run of inactive codes and confirms that no bit is accepted.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

    localparam int LVL_N = 13;

    typedef enum logic [1:0] {
        MOD_BPSK  = 2'd0,
        MOD_QPSK  = 2'd1,
        MOD_QAM16 = 2'd2,
        MOD_QAM64 = 2'd3
    } mod_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_GATHER,
        ST_MAP
    } st_e;

    function automatic logic [2:0] bits_for(input mod_e m);
        unique case (m)
            MOD_BPSK:  return 3'd1;
            MOD_QPSK:  return 3'd2;
            MOD_QAM16: return 3'd4;
            default:   return 3'd6;
        endcase
    endfunction

    // first level-table entry owned by each constellation
    function automatic int unsigned lvl_base(input mod_e m);
        unique case (m)
            MOD_BPSK:  return 0;
            MOD_QPSK:  return 1;
            MOD_QAM16: return 3;
            default:   return 7;
        endcase
    endfunction

endpackage

// File: rtl/cmap_code_sel.sv
module cmap_code_sel
    import cmap_pkg::*;
#(
    parameter int NUM_SC = 200,
    parameter int IDX_W  = $clog2(NUM_SC)
) (
    input  logic [NUM_SC*4-1:0] info_tbl,
    input  logic [IDX_W-1:0]    idx,
    output logic                active,
    output mod_e                mod
);
    logic [3:0] codes [NUM_SC];

    for (genvar j = 0; j < NUM_SC; j++) begin : g_code
        assign codes[j] = info_tbl[j*4 +: 4];
    end

    logic [3:0] code;
    assign code   = codes[idx];
    // bit 3 switches the subcarrier on; types 4..7 are reserved and treated as off
    assign active = code[3] & ~code[2];
    assign mod    = mod_e'(code[1:0]);

endmodule

// File: rtl/cmap_sym_map.sv
module cmap_sym_map
    import cmap_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic                 active,
    input  mod_e                 mod,
    input  logic [5:0]           bits,
    input  logic signed [LW-1:0] lv [LVL_N],
    output logic signed [LW-1:0] sym_i,
    output logic signed [LW-1:0] sym_q
);
    function automatic logic signed [LW-1:0] apply_sign(input logic neg,
                                                        input logic signed [LW-1:0] v);
        return neg ? -v : v;
    endfunction

    function automatic logic signed [LW-1:0] pick4(input logic [1:0] s,
                                                   input logic signed [LW-1:0] a,
                                                   input logic signed [LW-1:0] b,
                                                   input logic signed [LW-1:0] c);
        unique case (s)
            2'd0:    return '0;
            2'd1:    return a;
            2'd2:    return b;
            default: return c;
        endcase
    endfunction

    int unsigned base;

    always_comb begin
        base  = lvl_base(mod);
        sym_i = '0;
        sym_q = '0;
        unique case (mod)
            MOD_BPSK: begin
                sym_i = apply_sign(bits[0], lv[base]);
            end
            MOD_QPSK: begin
                sym_i = apply_sign(bits[0], lv[base]);
                sym_q = apply_sign(bits[1], lv[base+1]);
            end
            MOD_QAM16: begin
                sym_i = apply_sign(bits[0], bits[1] ? lv[base+1] : lv[base]);
                sym_q = apply_sign(bits[2], bits[3] ? lv[base+3] : lv[base+2]);
            end
            default: begin
                sym_i = apply_sign(bits[0], pick4(bits[2:1], lv[base], lv[base+1], lv[base+2]));
                sym_q = apply_sign(bits[3], pick4(bits[5:4], lv[base+3], lv[base+4], lv[base+5]));
            end
        endcase
        if (!active) begin
            sym_i = '0;
            sym_q = '0;
        end
    end

endmodule

// File: rtl/cmap_mapper.sv
module cmap_mapper
    import cmap_pkg::*;
#(
    parameter int NUM_SC = 200,
    parameter int LW     = 16,
    localparam int IDX_W = $clog2(NUM_SC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SC*4-1:0]     info_tbl,
    input  logic [LVL_N*LW-1:0]     lvl_tbl,
    input  logic                    in_valid,
    input  logic                    in_bit,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [LW-1:0]    out_i,
    output logic signed [LW-1:0]    out_q,
    output logic [IDX_W-1:0]        out_sc
);
    localparam logic [IDX_W-1:0] LAST_SC = IDX_W'(NUM_SC - 1);

    st_e                  state, nxt;
    logic [IDX_W-1:0]     sc_cnt, cur_sc, s1_sc;
    logic                 cur_active, sel_active;
    mod_e                 cur_mod, sel_mod;
    logic [5:0]           bit_buf;
    logic [2:0]           bit_cnt, cur_nbits;
    logic                 s1_valid;
    logic signed [LW-1:0] s1_i, s1_q, map_i, map_q;
    logic signed [LW-1:0] lv [LVL_N];

    for (genvar k = 0; k < LVL_N; k++) begin : g_lvl
        assign lv[k] = lvl_tbl[k*LW +: LW];
    end

    cmap_code_sel #(.NUM_SC(NUM_SC), .IDX_W(IDX_W)) u_sel (
        .info_tbl (info_tbl),
        .idx      (sc_cnt),
        .active   (sel_active),
        .mod      (sel_mod)
    );

    cmap_sym_map #(.LW(LW)) u_map (
        .active (cur_active),
        .mod    (cur_mod),
        .bits   (bit_buf),
        .lv     (lv),
        .sym_i  (map_i),
        .sym_q  (map_q)
    );

    assign cur_nbits = bits_for(cur_mod);
    assign in_ready  = (state == ST_GATHER);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  nxt = sel_active ? ST_GATHER : ST_MAP;
            ST_GATHER: nxt = (in_valid && bit_cnt == cur_nbits - 3'd1) ? ST_MAP : ST_GATHER;
            ST_MAP:    nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_cnt     <= '0;
            cur_sc     <= '0;
            cur_active <= 1'b0;
            cur_mod    <= MOD_BPSK;
            bit_buf    <= '0;
            bit_cnt    <= '0;
            s1_valid   <= 1'b0;
            s1_i       <= '0;
            s1_q       <= '0;
            s1_sc      <= '0;
            out_valid  <= 1'b0;
            out_i      <= '0;
            out_q      <= '0;
            out_sc     <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    cur_active <= sel_active;
                    cur_mod    <= sel_mod;
                    cur_sc     <= sc_cnt;
                    sc_cnt     <= (sc_cnt == LAST_SC) ? '0 : sc_cnt + 1'b1;
                    bit_buf    <= '0;
                    bit_cnt    <= '0;
                end
                ST_GATHER: begin
                    if (in_valid) begin
                        bit_buf[bit_cnt] <= in_bit;
                        bit_cnt          <= bit_cnt + 3'd1;
                    end
                end
                default: ;
            endcase
            s1_valid <= (state == ST_MAP);
            if (state == ST_MAP) begin
                s1_i  <= map_i;
                s1_q  <= map_q;
                s1_sc <= cur_sc;
            end
            out_valid <= s1_valid;
            out_i     <= s1_i;
            out_q     <= s1_q;
            out_sc    <= s1_sc;
        end
    end

    // checker state: last emitted subcarrier index
    logic [IDX_W-1:0] chk_prev_sc;
    logic             chk_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_prev_sc <= '0;
            chk_seen    <= 1'b0;
        end else if (out_valid) begin
            chk_prev_sc <= out_sc;
            chk_seen    <= 1'b1;
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r9_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state, 2) == ST_MAP);

    a_r7_no_ready_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> cur_active);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_cnt < cur_nbits);

    a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && chk_seen) |-> out_sc == ((chk_prev_sc == LAST_SC) ? '0 : chk_prev_sc + 1'b1));

endmodule

// File: tb/cmap_mapper_bench.sv
module cmap_mapper_bench;
    localparam int NSC = 200;
    localparam int LW  = 16;
    localparam int NL  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NSC*4-1:0]     info;
    logic [NL*LW-1:0]     lvl;
    logic                 in_valid = 1'b0;
    logic                 in_bit = 1'b0;
    logic                 in_ready, out_valid;
    logic signed [LW-1:0] out_i, out_q;
    logic [7:0]           out_sc;

    cmap_mapper #(.NUM_SC(NSC), .LW(LW)) u_cmap_mapper (
        .clk(clk), .rst_n(rst_n), .info_tbl(info), .lvl_tbl(lvl),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_sc(out_sc)
    );

    int errors = 0, checks = 0;
    int cyc = 0, acc_tot = 0, last_acc = 0;
    int n_rec = 0, rp = 0;
    logic signed [15:0] r_i [1024];
    logic signed [15:0] r_q [1024];
    int r_sc [1024];
    int r_cyc [1024];
    logic signed [15:0] lvb [NL];
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_valid && in_ready) acc_tot <= acc_tot + 1;
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid && n_rec < 1024) begin
            r_i[n_rec] = out_i; r_q[n_rec] = out_q;
            r_sc[n_rec] = out_sc; r_cyc[n_rec] = cyc;
            n_rec = n_rec + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic next_bit(output logic b);
        b  = lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    endtask

    task automatic load_levels(input int scale, input int offs);
        for (int k = 0; k < NL; k++) begin
            lvb[k] = 16'(offs + scale * k);
            lvl[16*k +: 16] = lvb[k];
        end
    endtask

    task automatic load_mixed;
        logic [3:0] pat [8];
        pat = '{4'h8, 4'h9, 4'hA, 4'hB, 4'h0, 4'h3, 4'hE, 4'hB};
        for (int j = 0; j < NSC; j++) info[4*j +: 4] = pat[j % 8];
    endtask

    task automatic apply_reset;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
        chk(out_i == 0 && out_q == 0, "R1", "I/Q in reset", int'(out_i), 0);
        rst_n = 1'b1;
        rp = n_rec;
    endtask

    task automatic exp_sym(input logic [3:0] c, input logic [5:0] b,
                           output logic signed [15:0] ei, output logic signed [15:0] eq);
        logic [1:0] mi, mq;
        ei = 0; eq = 0;
        if (c[3] && !c[2]) begin
            case (c[1:0])
                2'd0: ei = b[0] ? -lvb[0] : lvb[0];
                2'd1: begin
                    ei = b[0] ? -lvb[1] : lvb[1];
                    eq = b[1] ? -lvb[2] : lvb[2];
                end
                2'd2: begin
                    ei = b[0] ? -lvb[3 + b[1]] : lvb[3 + b[1]];
                    eq = b[2] ? -lvb[5 + b[3]] : lvb[5 + b[3]];
                end
                default: begin
                    mi = {b[2], b[1]};
                    mq = {b[5], b[4]};
                    if (mi != 0) ei = b[0] ? -lvb[6 + mi] : lvb[6 + mi];
                    if (mq != 0) eq = b[3] ? -lvb[9 + mq] : lvb[9 + mq];
                end
            endcase
        end
    endtask

    task automatic send_bit(input logic b);
        int t = 0;
        in_bit = b;
        in_valid = 1'b1;
        while (!in_ready && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        last_acc = cyc;
    endtask

    task automatic wait_rec(output bit got);
        int t = 0;
        while (n_rec <= rp && t < 200) begin @(negedge clk); t++; end
        got = (n_rec > rp);
        if (!got) chk(0, "R9", "output record missing", 0, 1);
    endtask

    // runs one subcarrier through the mapper and checks its sample
    task automatic do_sc(input int j, input string tag_over);
        logic [3:0] c;
        logic [5:0] b;
        logic bt;
        logic signed [15:0] ei, eq;
        int n, idx;
        bit on, got;
        string tag;
        idx = j % NSC;
        c = info[4*idx +: 4];
        on = c[3] && !c[2];
        n = (c[1:0] == 0) ? 1 : (c[1:0] == 1) ? 2 : (c[1:0] == 2) ? 4 : 6;
        if (tag_over != "") tag = tag_over;
        else if (!on) tag = "R7";
        else tag = (c[1:0] == 0) ? "R3" : (c[1:0] == 1) ? "R4" : (c[1:0] == 2) ? "R5" : "R6";
        b = '0;
        if (on) begin
            for (int k = 0; k < n; k++) begin
                next_bit(bt);
                b[k] = bt;
                send_bit(bt);
            end
            in_valid = 1'b0;
            chk(in_ready == 1'b0, "R2", "ready after last bit", int'(in_ready), 0);
        end
        wait_rec(got);
        if (got) begin
            exp_sym(c, b, ei, eq);
            chk(r_sc[rp] == idx, "R8", "subcarrier index", r_sc[rp], idx);
            chk(r_i[rp] == ei, tag, "I value", int'(r_i[rp]), int'(ei));
            chk(r_q[rp] == eq, tag, "Q value", int'(r_q[rp]), int'(eq));
            if (on) chk(r_cyc[rp] == last_acc + 2, "R9", "latency edge", r_cyc[rp], last_acc + 2);
            if (rp + 1 < n_rec) chk(r_cyc[rp+1] != r_cyc[rp] + 1, "R9", "back-to-back valid", r_cyc[rp+1], 0);
            rp++;
        end
    endtask

    task automatic t_all_off;
        int acc0, t;
        for (int j = 0; j < NSC; j++)
            info[4*j +: 4] = (j % 3 == 0) ? (4'hC | 4'(j % 4)) : 4'(j % 8);
        apply_reset();
        acc0 = acc_tot;
        in_bit = 1'b1;
        in_valid = 1'b1;
        t = 0;
        while (n_rec < rp + 210 && t < 2000) begin @(negedge clk); t++; end
        chk(n_rec >= rp + 210, "R7", "inactive outputs produced", n_rec - rp, 210);
        for (int k = 0; k < 210 && rp + k < n_rec; k++) begin
            chk(r_i[rp+k] == 0 && r_q[rp+k] == 0, "R7", "inactive I/Q", int'(r_i[rp+k]), 0);
            chk(r_sc[rp+k] == k % NSC, "R8", "index with wrap", r_sc[rp+k], k % NSC);
        end
        chk(acc_tot == acc0, "R7", "bits taken while inactive", acc_tot - acc0, 0);
        in_valid = 1'b0;
    endtask

    task automatic t_mixed;
        load_mixed();
        load_levels(250, 1000);
        apply_reset();
        for (int j = 0; j < NSC + 4; j++) do_sc(j, "");
    endtask

    task automatic t_new_levels;
        load_mixed();
        load_levels(-123, -500);
        apply_reset();
        for (int j = 0; j < 16; j++) do_sc(j, "R10");
    endtask

    initial begin
        load_mixed();
        load_levels(250, 1000);
        repeat (2) @(negedge clk);
        t_all_off();
        t_mixed();
        t_new_levels();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule